// File: doc/BRIEF.md
# 64-bit Integer Shift Execution Unit

This block carries out the shift instructions of a 64-bit integer pipeline. It takes the raw 32-bit instruction word, the value read for the first source register and the value read for the second source register. It decodes which of six shift operations is requested and registers the 64-bit result one cycle after an accepted issue. The six operations are a left shift, a logical right shift and an arithmetic right shift, each in a 32-bit form and a 64-bit form. For the register file it also brings out the two source register numbers, taken directly from the instruction word.

The shift amount comes from one of two places. When the immediate bit is set it comes from the low bits of the instruction; otherwise it comes from the second register value. Only its low 5 bits are used for the 32-bit forms, and only its low 6 bits for the 64-bit forms. The 32-bit forms run on the full 64-bit datapath. The logical right form clears the upper word before shifting. The arithmetic right form sign-extends bit 31 before shifting. The left form keeps every bit shifted into the upper word.

The unit has no state machine. A single valid flag and a result register are the only state, and both return to zero on reset.

Top module: `shift_unit`

## Requirements
- R1: An issue is accepted when `in_valid` is 1, instruction bits 31:30 equal 2'b10, and instruction bits 24:19 hold 0x25 (left), 0x26 (logical right) or 0x27 (arithmetic right). Any other issue leaves `out_valid` at 0 on the next cycle and `result` unchanged.
- R2: In the 32-bit forms (instruction bit 12 clear), only count bits 4:0 are used. A count of 32 shifts by zero, so a left shift by 32 returns the operand unchanged.
- R3: In the 64-bit forms (instruction bit 12 set), only count bits 5:0 are used, so a count of 64 shifts by zero.
- R4: When instruction bit 13 is set, the count is taken from instruction bits 5:0; otherwise it is taken from `rs2_val`.
- R5: The 32-bit left shift returns the full 64-bit shifted operand, upper word included.
- R6: The 32-bit logical right shift zeroes operand bits 63:32 before shifting, so result bits 63:32 are always 0.
- R7: The 32-bit arithmetic right shift replaces operand bits 63:32 with copies of bit 31 before shifting.
- R8: The 64-bit arithmetic right shift fills the vacated high bits with operand bit 63. The 64-bit logical right and left shifts fill them with zeros.
- R9: `rs1_idx` equals instruction bits 18:14 and `rs2_idx` equals instruction bits 4:0, combinationally and regardless of the opcode.
- R10: Reset clears `out_valid` and `result` to 0. An accepted issue sets `out_valid` and loads `result` on the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe |
| insn | input | 32 | Instruction word |
| rs1_val | input | 64 | Value to be shifted |
| rs2_val | input | 64 | Register shift count |
| rs1_idx | output | 5 | First source register number |
| rs2_idx | output | 5 | Second source register number |
| out_valid | output | 1 | Result valid, one cycle after an accepted issue |
| result | output | 64 | Registered shift result |

## Verification
The register numbers are combinational, so the bench reads them in the same half-cycle in which it drives the instruction. Every shift result and the valid flag pass through exactly one register. The bench drives inputs on a falling edge and compares outputs on the next falling edge, half a period after the rising edge that loads them. The hold cases for R1 follow the same rule: the bench compares `result` one cycle after a rejected issue against the value it had before that issue.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
    localparam int XLEN   = 64;
    localparam int HALF   = XLEN / 2;
    localparam int CNT_W  = $clog2(XLEN);
    localparam int IDX_W  = 5;

    localparam logic [5:0] OP3_LEFT   = 6'h25;
    localparam logic [5:0] OP3_RLOG   = 6'h26;
    localparam logic [5:0] OP3_RARITH = 6'h27;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_LEFT   = 2'd1,
        SH_RLOG   = 2'd2,
        SH_RARITH = 2'd3
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e kind;
        logic        wide;
        logic        use_imm;
        logic [CNT_W-1:0] imm_cnt;
    } shift_ctl_t;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
    import shift_unit_pkg::*;
(
    input  logic [31:0]      insn,
    output shift_ctl_t       ctl,
    output logic [IDX_W-1:0] src1_num,
    output logic [IDX_W-1:0] src2_num
);
    logic [1:0] fmt;
    logic [5:0] op3;

    assign fmt      = insn[31:30];
    assign op3      = insn[24:19];
    assign src1_num = insn[18:14];
    assign src2_num = insn[4:0];

    always_comb begin
        ctl.kind    = SH_NONE;
        ctl.wide    = insn[12];
        ctl.use_imm = insn[13];
        ctl.imm_cnt = insn[CNT_W-1:0];
        if (fmt == 2'b10) begin
            unique case (op3)
                OP3_LEFT:   ctl.kind = SH_LEFT;
                OP3_RLOG:   ctl.kind = SH_RLOG;
                OP3_RARITH: ctl.kind = SH_RARITH;
                default:    ctl.kind = SH_NONE;
            endcase
        end
    end
endmodule

// File: rtl/shift_count.sv
module shift_count
    import shift_unit_pkg::*;
(
    input  shift_ctl_t       ctl,
    input  logic [XLEN-1:0]  reg_cnt,
    output logic [CNT_W-1:0] amount
);
    logic [CNT_W-1:0] raw;

    assign raw = ctl.use_imm ? ctl.imm_cnt : reg_cnt[CNT_W-1:0];

    // The narrow forms drop the top count bit (modulo half the width).
    always_comb begin
        amount = raw;
        if (!ctl.wide)
            amount[CNT_W-1] = 1'b0;
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_unit_pkg::*;
(
    input  shift_ctl_t       ctl,
    input  logic [XLEN-1:0]  operand,
    input  logic [CNT_W-1:0] amount,
    output logic [XLEN-1:0]  shifted
);
    logic [XLEN-1:0] prepared;
    logic            go_left;
    logic            fill;

    // Narrow right shifts see only the low word, zero- or sign-extended.
    always_comb begin
        prepared = operand;
        if (!ctl.wide) begin
            unique case (ctl.kind)
                SH_RLOG:   prepared = {{HALF{1'b0}}, operand[HALF-1:0]};
                SH_RARITH: prepared = {{HALF{operand[HALF-1]}}, operand[HALF-1:0]};
                default:   prepared = operand;
            endcase
        end
    end

    assign go_left = (ctl.kind == SH_LEFT);
    assign fill    = (ctl.kind == SH_RARITH) & prepared[XLEN-1];

    logic [XLEN-1:0] stage [0:CNT_W];
    assign stage[0] = prepared;

    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [XLEN-1:0] moved;
        always_comb begin
            if (go_left)
                moved = {stage[k][XLEN-STEP-1:0], {STEP{1'b0}}};
            else
                moved = {{STEP{fill}}, stage[k][XLEN-1:STEP]};
        end
        assign stage[k+1] = amount[k] ? moved : stage[k];
    end

    assign shifted = stage[CNT_W];
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic [XLEN-1:0]   rs1_val,
    input  logic [XLEN-1:0]   rs2_val,
    output logic [IDX_W-1:0]  rs1_idx,
    output logic [IDX_W-1:0]  rs2_idx,
    output logic              out_valid,
    output logic [XLEN-1:0]   result
);
    shift_ctl_t       ctl;
    logic [CNT_W-1:0] amount;
    logic [XLEN-1:0]  shifted;
    logic             accept;

    shift_decode u_decode (
        .insn     (insn),
        .ctl      (ctl),
        .src1_num (rs1_idx),
        .src2_num (rs2_idx)
    );

    shift_count u_count (
        .ctl     (ctl),
        .reg_cnt (rs2_val),
        .amount  (amount)
    );

    shift_core u_core (
        .ctl     (ctl),
        .operand (rs1_val),
        .amount  (amount),
        .shifted (shifted)
    );

    assign accept = in_valid && (ctl.kind != SH_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= accept;
            if (accept)
                result <= shifted;
        end
    end
endmodule

// File: rtl/shift_unit_checker.sv
module shift_unit_checker
    import shift_unit_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     insn,
    input logic [XLEN-1:0] rs1_val,
    input logic            out_valid,
    input logic [XLEN-1:0] result
);
    logic is_shift;
    assign is_shift = (insn[31:30] == 2'b10) &&
                      (insn[24:19] == OP3_LEFT || insn[24:19] == OP3_RLOG ||
                       insn[24:19] == OP3_RARITH);

    assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_shift) |=> out_valid);

    assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && is_shift) |=> (!out_valid && $stable(result)));

    assert_narrow_srl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_shift && insn[24:19] == OP3_RLOG && !insn[12])
        |=> (result[XLEN-1:HALF] == '0));

    assert_narrow_sra_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_shift && insn[24:19] == OP3_RARITH && !insn[12])
        |=> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}));

    assert_wide_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_shift && insn[12] && insn[13] && insn[CNT_W-1:0] == '0)
        |=> (result == $past(rs1_val)));

    assert_narrow_left32_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_shift && insn[24:19] == OP3_LEFT && !insn[12] &&
         insn[13] && insn[CNT_W-1:0] == 6'd32)
        |=> (result == $past(rs1_val)));
endmodule

bind shift_unit shift_unit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .insn      (insn),
    .rs1_val   (rs1_val),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_shift_unit.sv
module sim_shift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] rs1_val = '0;
    logic [63:0] rs2_val = '0;
    logic [4:0]  rs1_idx;
    logic [4:0]  rs2_idx;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .rs1_idx(rs1_idx),
        .rs2_idx(rs2_idx), .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] mk(input logic [5:0] op3, input logic x,
                                       input logic i, input logic [4:0] r1,
                                       input logic [5:0] low);
        return {2'b10, 5'd3, op3, r1, i, x, 6'd0, low};
    endfunction

    function automatic logic [63:0] model(input logic [5:0] op3, input logic x,
                                          input logic i, input logic [5:0] imm,
                                          input logic [63:0] a, input logic [63:0] b);
        int c;
        logic [63:0] ext;
        c = i ? int'(imm) : int'(b[5:0]);
        c = x ? (c % 64) : (c % 32);
        case (op3)
            6'h25: return a << c;
            6'h26: begin
                ext = x ? a : {32'd0, a[31:0]};
                return ext >> c;
            end
            default: begin
                ext = x ? a : {{32{a[31]}}, a[31:0]};
                return 64'($signed(ext) >>> c);
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic run_shift(input string req, input logic [5:0] op3, input logic x,
                             input logic i, input logic [5:0] low,
                             input logic [63:0] a, input logic [63:0] b);
        logic [4:0] r1;
        r1 = 5'($urandom);
        @(negedge clk);
        in_valid = 1'b1;
        insn = mk(op3, x, i, r1, low);
        rs1_val = a;
        rs2_val = b;
        #1;
        check("R9 rs1_idx", 64'(rs1_idx), 64'(r1));
        check("R9 rs2_idx", 64'(rs2_idx), 64'(low[4:0]));
        @(negedge clk);
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check(req, result, model(op3, x, i, low, a, b));
        in_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic [63:0] pats [4];
        int counts [7];
        void'($urandom(32'd20240401));
        pats[0] = 64'h0000_0000_8000_0001;
        pats[1] = 64'h8000_0000_0000_0001;
        pats[2] = 64'hF0F0_1234_7654_ABCD;
        pats[3] = 64'h7FFF_FFFF_FFFF_FFFF;
        counts = '{0, 1, 31, 32, 33, 63, 64};

        #3;
        check("R10 reset valid", 64'(out_valid), 64'd0);
        check("R10 reset result", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed sweep: register-form counts (64 only reachable via rs2)
        for (int p = 0; p < 4; p++)
            for (int c = 0; c < 7; c++)
                for (int g = 0; g < 3; g++)
                    for (int x = 0; x < 2; x++)
                        run_shift(x ? "R3/R8 wide" : "R2/R5/R6/R7 narrow",
                                  6'h25 + 6'(g), x[0], 1'b0, 6'd0,
                                  pats[p], 64'(counts[c]) | 64'hFFFF_FF00_0000_0000);

        // Immediate form: rs2 holds a misleading count (R4)
        run_shift("R4 imm sllx", 6'h25, 1'b1, 1'b1, 6'd4, 64'h1, 64'd9);
        run_shift("R4 imm srax", 6'h27, 1'b1, 1'b1, 6'd63, 64'h8000_0000_0000_0000, 64'd1);
        run_shift("R2 imm sll 32", 6'h25, 1'b0, 1'b1, 6'd32, 64'hDEAD_BEEF_1234_5678, 64'd3);
        run_shift("R5 sll upper kept", 6'h25, 1'b0, 1'b1, 6'd8, 64'h0000_0000_FF00_0000, 64'd0);

        // R1: rejected issues hold result and drop valid
        held = result;
        @(negedge clk);
        in_valid = 1'b1;
        insn = mk(6'h02, 1'b0, 1'b1, 5'd1, 6'd1);
        rs1_val = 64'h1234;
        @(negedge clk);
        check("R1 other op3 valid", 64'(out_valid), 64'd0);
        check("R1 other op3 hold", result, held);
        insn = {2'b11, mk(6'h25, 1'b0, 1'b1, 5'd1, 6'd1)} [31:0];
        insn[31:30] = 2'b11;
        @(negedge clk);
        check("R1 wrong format valid", 64'(out_valid), 64'd0);
        check("R1 wrong format hold", result, held);
        in_valid = 1'b0;
        insn = mk(6'h25, 1'b0, 1'b1, 5'd1, 6'd1);
        @(negedge clk);
        check("R1 no strobe valid", 64'(out_valid), 64'd0);
        check("R1 no strobe hold", result, held);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [5:0] op3;
            op3 = 6'h25 + 6'($urandom_range(0, 2));
            run_shift("R2/R3/R4/R8 random", op3, 1'($urandom), 1'($urandom),
                      6'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
        end

        // R10: reset clears state again
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 reset mid-run valid", 64'(out_valid), 64'd0);
        check("R10 reset mid-run result", result, 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule